// File: doc/BRIEF.md
# Polynomial Code Correction Unit

This unit sits in the output path of a data converter and repairs each raw code as it streams through. It does not keep one error value per code. It holds four signed fixed-point coefficients that describe a cubic estimate of the integral nonlinearity. For every incoming code x it evaluates that cubic in nested (Horner) form and rounds the result to whole codes. It then subtracts the rounded value from x and clamps the outcome to the legal code range.

Samples enter and leave on valid/ready handshakes. Throughput is one code per clock, and latency is a fixed three cycles. A stalled output freezes the whole pipeline. The coefficients are written through a small register port. A write is honoured only while the pipeline holds no sample, which the `idle_o` flag reports. A per-sample bypass flag sends the raw code through unchanged, with the same latency as a corrected code.

Top module: `poly_code_corrector`

## Requirements
- R1: For each accepted code x with bypass low, the output equals x − round(P(x)), where P(x) = ((b3·x + b2)·x + b1)·x + b0. The coefficients b0..b3 are signed 16-bit values with 8 fractional bits, and P(x) is carried exactly until the rounding step.
- R2: Rounding adds one half LSB and then floors. A fraction of exactly +0.5 rounds up, −0.5 rounds to 0, and −0.504 rounds to −1.
- R3: If x − round(P(x)) is below 0 the output is 0, and if it is above 16383 the output is 16383. The value never wraps.
- R4: A code accepted at a clock edge appears on `out_valid_o` after the third rising edge, counting the accepting edge. With `out_ready_i` held high, one code is accepted on every cycle.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_code_o` holds its value and `in_ready_o` is low. No sample is lost or duplicated.
- R6: A write with `cfg_we_i` high while `idle_o` is high stores `cfg_data_i` into the coefficient selected by `cfg_addr_i`: 0 selects b0, 1 selects b1, 2 selects b2 and 3 selects b3.
- R7: A write attempted while `idle_o` is low leaves all coefficients unchanged. Later corrected codes show that nothing changed.
- R8: During any cycle with `cfg_we_i` high, `in_ready_o` is low, so no sample is accepted in the same cycle as a coefficient write.
- R9: A sample accepted with `bypass_i` high leaves with its code unchanged and the same latency as a corrected sample.
- R10: After reset all coefficients are zero, `out_valid_o` is low and `idle_o` is high. `idle_o` is high exactly when no sample is inside the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 2 | Coefficient select: 0..3 picks b0..b3 |
| cfg_data_i | input | 16 | Signed coefficient value, 8 fractional bits |
| idle_o | output | 1 | No sample in flight; writes are honoured |
| bypass_i | input | 1 | Pass this sample through uncorrected |
| in_valid_i | input | 1 | Input code valid |
| in_code_i | input | 14 | Raw converter code |
| in_ready_o | output | 1 | Input code accepted when high with valid |
| out_valid_o | output | 1 | Corrected code valid |
| out_code_o | output | 14 | Corrected code |
| out_ready_i | input | 1 | Downstream accepts the output |

## Verification
The hardest case to reach is a coefficient write that lands while a sample is still in flight. Only there does the ignore rule matter. A mismatch would show up later as a code corrected with a mix of old and new coefficients. The directed part parks one sample in the pipeline behind a held-low `out_ready_i`, writes into that window, and then drains. The random part makes writes, stalls and bursts at random, so writes fall on both busy and idle cycles many times. The bench model decides whether each write counts from how many samples it holds outstanding.

// File: rtl/poly_corr_pkg.sv
package poly_corr_pkg;

  localparam int unsigned NUM_COEF   = 4;
  localparam int unsigned POLY_ORDER = NUM_COEF - 1;

  typedef enum logic [1:0] {
    COEF_B0 = 2'd0,
    COEF_B1 = 2'd1,
    COEF_B2 = 2'd2,
    COEF_B3 = 2'd3
  } coef_sel_e;

  // exact width of the nested evaluation: each step multiplies by a
  // (code_w+1)-bit signed code and adds one coefficient
  function automatic int unsigned acc_width(int unsigned code_w, int unsigned coef_w);
    return coef_w + POLY_ORDER * (code_w + 1) + POLY_ORDER;
  endfunction

endpackage

// File: rtl/poly_coef_bank.sv
module poly_coef_bank
  import poly_corr_pkg::*;
#(
  parameter int unsigned COEF_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [1:0]                         addr_i,
  input  logic [COEF_W-1:0]                  data_i,
  input  logic                               allow_i,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    coef_o
);

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    logic hit;
    assign hit = we_i && allow_i && (addr_i == 2'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coef_o[i] <= '0;
      end else if (hit) begin
        coef_o[i] <= data_i;
      end
    end
  end

endmodule

// File: rtl/poly_horner_step.sv
module poly_horner_step #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic                     vld_i,
  input  logic                     byp_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic                     vld_o,
  output logic                     byp_o,
  output logic [CODE_W-1:0]        code_o,
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [ACC_W-1:0] x_s;
  logic signed [ACC_W-1:0] c_s;
  logic signed [ACC_W-1:0] nxt;

  assign x_s = signed'(ACC_W'(code_i));
  assign c_s = ACC_W'(coef_i);
  assign nxt = acc_i * x_s + c_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      byp_o  <= 1'b0;
      code_o <= '0;
      acc_o  <= '0;
    end else if (adv_i) begin
      vld_o  <= vld_i;
      byp_o  <= byp_i;
      code_o <= code_i;
      acc_o  <= nxt;
    end
  end

endmodule

// File: rtl/poly_round_sat.sv
module poly_round_sat #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                    byp_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [CODE_W-1:0]       code_o
);

  localparam logic signed [ACC_W-1:0] HALF = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic signed [ACC_W-1:0] corr;
  logic signed [ACC_W-1:0] x_s;
  logic signed [ACC_W-1:0] diff;

  assign corr = (acc_i + HALF) >>> FRAC_W;
  assign x_s  = signed'(ACC_W'(code_i));
  assign diff = x_s - corr;

  always_comb begin
    if (byp_i) begin
      code_o = code_i;
    end else if (diff < 0) begin
      code_o = '0;
    end else if (diff > MAXV) begin
      code_o = '1;
    end else begin
      code_o = diff[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/poly_code_corrector.sv
module poly_code_corrector
  import poly_corr_pkg::*;
#(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [COEF_W-1:0] cfg_data_i,
  output logic              idle_o,
  input  logic              bypass_i,
  input  logic              in_valid_i,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [CODE_W-1:0] out_code_o,
  input  logic              out_ready_i
);

  localparam int unsigned ACC_W  = acc_width(CODE_W, COEF_W);
  localparam int unsigned STAGES = POLY_ORDER;

  logic [NUM_COEF-1:0][COEF_W-1:0] coef_q;

  logic                    vld_s  [STAGES+1];
  logic                    byp_s  [STAGES+1];
  logic [CODE_W-1:0]       code_s [STAGES+1];
  logic signed [ACC_W-1:0] acc_s  [STAGES+1];

  logic adv;
  logic busy;

  // whole pipeline moves together; a full last stage blocks on downstream
  assign adv        = !vld_s[STAGES] || out_ready_i;
  assign in_ready_o = adv && !cfg_we_i;

  always_comb begin
    busy = 1'b0;
    for (int k = 1; k <= STAGES; k++) busy = busy | vld_s[k];
  end
  assign idle_o = !busy;

  poly_coef_bank #(
    .COEF_W (COEF_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .allow_i (idle_o),
    .coef_o  (coef_q)
  );

  assign vld_s[0]  = in_valid_i && in_ready_o;
  assign byp_s[0]  = bypass_i;
  assign code_s[0] = in_code_i;
  assign acc_s[0]  = ACC_W'(signed'(coef_q[COEF_B3]));

  for (genvar k = 0; k < STAGES; k++) begin : g_step
    logic signed [COEF_W-1:0] step_coef;
    assign step_coef = signed'(coef_q[STAGES-1-k]);

    poly_horner_step #(
      .CODE_W (CODE_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .vld_i  (vld_s[k]),
      .byp_i  (byp_s[k]),
      .code_i (code_s[k]),
      .acc_i  (acc_s[k]),
      .coef_i (step_coef),
      .vld_o  (vld_s[k+1]),
      .byp_o  (byp_s[k+1]),
      .code_o (code_s[k+1]),
      .acc_o  (acc_s[k+1])
    );
  end

  poly_round_sat #(
    .CODE_W (CODE_W),
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W)
  ) u_round (
    .byp_i  (byp_s[STAGES]),
    .code_i (code_s[STAGES]),
    .acc_i  (acc_s[STAGES]),
    .code_o (out_code_o)
  );

  assign out_valid_o = vld_s[STAGES];

endmodule

// File: rtl/poly_corr_checker.sv
module poly_corr_checker #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned COEF_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_we_i,
  input logic [1:0]              cfg_addr_i,
  input logic [COEF_W-1:0]       cfg_data_i,
  input logic                    idle_o,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    out_valid_o,
  input logic                    out_ready_i,
  input logic [CODE_W-1:0]       out_code_o,
  input logic [3:0][COEF_W-1:0]  coef_q
);

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_code_o)));

  assert_stall_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_write_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && idle_o) |=> (coef_q[$past(cfg_addr_i)] == $past(cfg_data_i)));

  assert_write_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !idle_o) |=> $stable(coef_q));

  assert_write_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !in_ready_o);

  assert_idle_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !out_valid_o);

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !idle_o);

endmodule

bind poly_code_corrector poly_corr_checker #(
  .CODE_W (CODE_W),
  .COEF_W (COEF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_data_i  (cfg_data_i),
  .idle_o      (idle_o),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_code_o  (out_code_o),
  .coef_q      (coef_q)
);

// File: tb/sim_poly_code_corrector.sv
`timescale 1ns/1ps
module sim_poly_code_corrector;

  localparam int CODE_W = 14;
  localparam int COEF_W = 16;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [COEF_W-1:0] cfg_data = '0;
  logic idle;
  logic bypass = 1'b0;
  logic in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic in_ready;
  logic out_valid;
  logic [CODE_W-1:0] out_code;
  logic out_ready = 1'b0;

  always #2.5 clk = ~clk;

  poly_code_corrector u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_data_i  (cfg_data),
    .idle_o      (idle),
    .bypass_i    (bypass),
    .in_valid_i  (in_valid),
    .in_code_i   (in_code),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_code_o  (out_code),
    .out_ready_i (out_ready)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  longint mc [4];
  int exp_q [$];

  function automatic int model(int x, bit byp, longint c0, longint c1, longint c2, longint c3);
    longint acc;
    longint corr;
    longint r;
    if (byp) return x;
    acc  = c3;
    acc  = acc * x + c2;
    acc  = acc * x + c1;
    acc  = acc * x + c0;
    corr = (acc + 128) >>> 8;
    r    = x - corr;
    if (r < 0) r = 0;
    if (r > MAXC) r = MAXC;
    return int'(r);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, evaluate before next rising edge
  task automatic step(bit iv, int x, bit byp, bit ordy, bit we, int addr, int data);
    bit m_idle;
    bit fin;
    int e;
    @(negedge clk);
    in_valid = iv; in_code = CODE_W'(x); bypass = byp; out_ready = ordy;
    cfg_we = we; cfg_addr = 2'(addr); cfg_data = COEF_W'(data);
    #1;
    m_idle = (exp_q.size() == 0);
    check("R10", int'(idle), int'(m_idle));
    if (we) check("R8", int'(in_ready), 0);
    if (out_valid && !ordy) check("R5", int'(in_ready), 0);
    fin = iv && in_ready;
    if (out_valid && ordy) begin
      if (exp_q.size() == 0) check(cur_req, 1, 0);
      else begin
        e = exp_q.pop_front();
        check(cur_req, int'(out_code), e);
      end
    end
    if (fin) exp_q.push_back(model(x, byp, mc[0], mc[1], mc[2], mc[3]));
    if (we && m_idle) mc[addr] = longint'($signed(COEF_W'(data)));
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, 0, 0, 1, 0, 0, 0);
    check("R5", exp_q.size(), 0);
  endtask

  task automatic set_coefs(int c0, int c1, int c2, int c3);
    drain();
    step(0, 0, 0, 1, 1, 0, c0);
    step(0, 0, 0, 1, 1, 1, c1);
    step(0, 0, 0, 1, 1, 2, c2);
    step(0, 0, 0, 1, 1, 3, c3);
  endtask

  task automatic send(int x, bit byp);
    step(1, x, byp, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mc[i] = 0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", int'(out_valid), 0);
    check("R10", int'(idle), 1);
    @(negedge clk); rst_n = 1'b1;

    // R10: zero coefficients give identity
    cur_req = "R10";
    send(0, 0); send(1234, 0); send(MAXC, 0);
    drain();

    // R4: latency of one sample
    begin
      int n;
      @(negedge clk);
      in_valid = 1; in_code = 14'd77; bypass = 0; out_ready = 1;
      @(posedge clk); n = 1;
      @(negedge clk); in_valid = 0;
      #1;
      while (!out_valid && n < 10) begin
        @(posedge clk); n++;
        @(negedge clk); #1;
      end
      check("R4", n, 3);
      check("R4", int'(out_code), 77);
    end
    step(0, 0, 0, 1, 0, 0, 0);

    // R4: back-to-back throughput
    cur_req = "R4";
    for (int i = 0; i < 20; i++) begin
      send(i * 500, 0);
      check("R4", int'(in_ready), 1);
    end
    drain();

    // R6/R1: offset and linear term
    cur_req = "R6";
    set_coefs(640, 0, 0, 0);              // b0 = 2.5 -> corr 3
    send(1000, 0); drain();
    cur_req = "R1";
    set_coefs(-300, 64, 0, 0);            // b1 = 0.25
    send(4000, 0); send(16000, 0); send(3, 0); drain();
    set_coefs(100, -20, 1, 0);
    send(100, 0); send(200, 0); drain();

    // R2: rounding at the half point
    cur_req = "R2";
    set_coefs(128, 0, 0, 0);  send(1000, 0); drain();
    set_coefs(-128, 0, 0, 0); send(1000, 0); drain();
    set_coefs(-129, 0, 0, 0); send(1000, 0); drain();
    set_coefs(127, 0, 0, 0);  send(1000, 0); drain();

    // R3: saturation at both ends
    cur_req = "R3";
    set_coefs(0, 32767, 0, 0);  send(5000, 0); send(1, 0); drain();
    set_coefs(0, -32768, 0, 0); send(5000, 0); send(MAXC, 0); drain();
    set_coefs(1280, 0, 0, 0);   send(2, 0); drain();
    set_coefs(-1280, 0, 0, 0);  send(MAXC - 2, 0); drain();
    set_coefs(0, 0, 0, 1);      send(MAXC, 0); drain();

    // R9: bypass with active correction, interleaved
    cur_req = "R9";
    set_coefs(2560, 0, 0, 0);
    send(500, 1); send(500, 0); send(0, 1); send(MAXC, 1); drain();

    // R7: write while a sample is held in the pipeline
    cur_req = "R7";
    set_coefs(0, 0, 0, 0);
    step(1, 600, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 25600);
    step(0, 0, 0, 0, 1, 3, 100);
    step(1, 700, 0, 0, 1, 1, 256);
    drain();
    send(900, 0); drain();
    check("R7", int'(mc[0]), 0);

    // R5: stall with full pipeline
    cur_req = "R5";
    set_coefs(512, 32, 0, 0);
    send(100, 0); send(200, 0); send(300, 0);
    for (int i = 0; i < 5; i++) step(1, 400 + i, 0, 0, 0, 0, 0);
    drain();

    // random mix
    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      bit iv, byp, ordy, we;
      int x, addr, data, sel;
      iv   = ($urandom_range(0, 3) != 0);
      byp  = ($urandom_range(0, 7) == 0);
      ordy = ($urandom_range(0, 4) != 0);
      we   = ($urandom_range(0, 19) == 0);
      sel  = $urandom_range(0, 3);
      x    = (sel == 0) ? $urandom_range(0, 15) :
             (sel == 1) ? MAXC - $urandom_range(0, 15) : $urandom_range(0, MAXC);
      addr = $urandom_range(0, 3);
      data = (addr >= 2 && $urandom_range(0, 3) != 0) ? 0 :
             (addr == 1) ? $urandom_range(0, 600) - 300 :
             (addr == 0) ? $urandom_range(0, 60000) - 30000 :
                           $urandom_range(0, 65535) - 32768;
      step(iv, x, byp, ordy, we, addr, data);
    end
    drain();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule